// File: doc/BRIEF.md
# Trace Unit Power-Down Lock Controller

This block sits in front of the configuration register file of a trace unit. It decides whether each register-bus access may reach that file. The decision rests on two pieces of state. The first is an OS lock, which software sets before a save or restore. The second is a sticky power-lost flag, raised when the trace unit's core domain loses power. While either one is active, direct accesses to the trace registers are refused with an error response.

While the lock is held, the trace registers can only be reached through a save/restore port. Each access to that port moves one register to or from the bus. It then advances an internal pointer that walks the registers in index order and wraps after the last one. A save clears the sticky flag by reading the power-down status register, sets the lock, and then reads every register through the port. A restore clears the flag, sets the lock, writes every register back through the port, and then releases the lock. A core-power-lost input event stands in for a real power switch.

The `FULL_PD` parameter selects one of two builds. In the full power-down build all of the above is present. In the single-power build there is no lock and no save/restore, and the status registers read as fixed values.

Top module: `trace_pd_lock`

Register map (word addresses, `ADDR_W` = 8 defaults):
- 0 to `NUM_TREGS`-1: trace registers.
- `0xC0`: lock-access register (write).
- `0xC1`: lock-status register.
- `0xC2`: save/restore port.
- `0xC5`: power-down status register.

## Requirements
- R1: In the full build, the lock-status register reads 0x1 when unlocked and 0x3 when locked. Bit 0 means lock support is present, bit 1 is the lock state, and bit 3 is always 0. In the single-power build it reads 0x0.
- R2: The power-down status register always has bit 0 = 1. Bit 1 is the sticky power-lost flag in the full build. In the single-power build the register always reads 0x1.
- R3: A read of the power-down status register returns the flag as it stood before the read, then clears it. If `pwr_lost` is asserted in the same cycle as that read, the flag ends up set.
- R4: In the full build, a `pwr_lost` pulse does three things. It sets the sticky flag, it clears every trace register to zero, and it returns the save/restore pointer to register 0.
- R5: A write of `LOCK_KEY` to the lock-access register sets the lock and returns the save/restore pointer to register 0. A write of any other value clears the lock.
- R6: In the full build, a trace-register access made while the lock or the sticky flag is set gets an error response. A refused write leaves the register unchanged, and a refused read returns 0.
- R7: With neither the lock nor the flag set, trace registers can be written and read back without error.
- R8: In the full build, an access to the save/restore port while unlocked gets an error response and moves nothing.
- R9: While locked, each save/restore read returns the register at the pointer, and each save/restore write loads the register at the pointer. Either one advances the pointer, which wraps from `NUM_TREGS`-1 to 0.
- R10: Accesses to the lock-access, lock-status, power-down status and unmapped addresses never get an error. Reads of unmapped addresses return 0.
- R11: In the single-power build, several things have no effect. Lock-access writes and `pwr_lost` change nothing, and trace registers stay accessible at all times. The save/restore port reads 0 without error and ignores writes.
- R12: Every request gets exactly one response cycle. `rsp_vld`, `rsp_rdata` and `rsp_err` are valid in the cycle after `bus_req`. Write responses carry rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_lost | input | 1 | One-cycle core-power-lost event |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Error response |

## Verification
The bench builds two instances side by side, both with `NUM_TREGS` = 4.

The first instance uses `FULL_PD` = 1. With only four registers, a few save/restore accesses are enough to cross the pointer wrap. They also show that the pointer is reset by a power-lost event and by a repeated key write. This instance also covers the corner case where a power-lost event lands on the same cycle as a status read.

The second instance uses `FULL_PD` = 0. It shows the fixed status values, and shows that lock keys and power-lost events have no effect in the single-power build.

// File: rtl/trace_pd_lock.sv
module trace_pd_lock #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_TREGS = 16,
  parameter int FULL_PD   = 1,
  parameter logic [DATA_W-1:0] LOCK_KEY = 32'h5EC0_10CC,
  parameter logic [ADDR_W-1:0] A_LOCK_ACC  = 8'hC0,
  parameter logic [ADDR_W-1:0] A_LOCK_STAT = 8'hC1,
  parameter logic [ADDR_W-1:0] A_SAVE_RST  = 8'hC2,
  parameter logic [ADDR_W-1:0] A_PD_STAT   = 8'hC5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_lost,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam bit FULL  = (FULL_PD != 0);
  localparam int PTR_W = (NUM_TREGS > 1) ? $clog2(NUM_TREGS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_TREGS - 1);

  logic [DATA_W-1:0] tregs [NUM_TREGS];
  logic              lock_q, sticky_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] rd_val;
  logic              err_val;

  wire is_trace = (int'(bus_addr) < NUM_TREGS);
  wire [PTR_W-1:0] tidx = bus_addr[PTR_W-1:0];
  wire is_la  = (bus_addr == A_LOCK_ACC);
  wire is_ls  = (bus_addr == A_LOCK_STAT);
  wire is_sr  = (bus_addr == A_SAVE_RST);
  wire is_pd  = (bus_addr == A_PD_STAT);
  wire blocked  = FULL && (lock_q || sticky_q);
  wire sr_go    = FULL && bus_req && is_sr && lock_q;
  wire key_wr   = FULL && bus_req && bus_we && is_la && (bus_wdata == LOCK_KEY);
  wire lost     = FULL && pwr_lost;
  wire [PTR_W-1:0] ptr_nxt = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    rd_val  = '0;
    err_val = 1'b0;
    if (is_trace) begin
      if (blocked) err_val = 1'b1;
      else if (!bus_we) rd_val = tregs[tidx];
    end else if (is_ls) begin
      if (!bus_we && FULL) rd_val = DATA_W'({lock_q, 1'b1});
    end else if (is_pd) begin
      if (!bus_we) rd_val = DATA_W'({FULL && sticky_q, 1'b1});
    end else if (is_sr && FULL) begin
      if (!lock_q) err_val = 1'b1;
      else if (!bus_we) rd_val = tregs[ptr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_vld   <= bus_req;
      rsp_rdata <= bus_req ? rd_val : '0;
      rsp_err   <= bus_req && err_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      sticky_q <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (FULL && bus_req && bus_we && is_la) lock_q <= (bus_wdata == LOCK_KEY);
      if (lost) sticky_q <= 1'b1;
      else if (bus_req && !bus_we && is_pd) sticky_q <= 1'b0;
      if (lost || key_wr) ptr_q <= '0;
      else if (sr_go) ptr_q <= ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || lost) begin
      for (int i = 0; i < NUM_TREGS; i++) tregs[i] <= '0;
    end else if (bus_req && bus_we && is_trace && !blocked) begin
      tregs[tidx] <= bus_wdata;
    end else if (sr_go && bus_we) begin
      tregs[ptr_q] <= bus_wdata;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) bus_req |=> rsp_vld); // R12
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !bus_req |=> !rsp_vld); // R12
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (FULL && pwr_lost) |=> sticky_q); // R4
  AST_TRACE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && is_trace && (lock_q || sticky_q)) |=> rsp_err); // R6
  AST_SR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (FULL && bus_req && is_sr && !lock_q) |=> rsp_err); // R8
  AST_CTRL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (is_la || is_ls || is_pd)) |=> !rsp_err); // R10
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ptr_q <= PTR_LAST); // R9
  AST_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) key_wr |=> lock_q); // R5
endmodule

// File: tb/trace_pd_lock_tb.sv
`timescale 1ns/1ps
module trace_pd_lock_tb_top;
  localparam logic [31:0] KEY = 32'h5EC0_10CC;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_f = 1'b0, req_s = 1'b0, lost_f = 1'b0, lost_s = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic f_vld, f_err, s_vld, s_err;
  logic [31:0] f_rd, s_rd;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  trace_pd_lock #(.NUM_TREGS(4), .FULL_PD(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_lost(lost_f), .bus_req(req_f), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .rsp_vld(f_vld), .rsp_rdata(f_rd), .rsp_err(f_err));
  trace_pd_lock #(.NUM_TREGS(4), .FULL_PD(0)) dut_single_i (
    .clk(clk), .rst_n(rst_n), .pwr_lost(lost_s), .bus_req(req_s), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .rsp_vld(s_vld), .rsp_rdata(s_rd), .rsp_err(s_err));

  // {we, addr, wdata, exp_rdata, exp_err, req#}
  localparam int NV = 26;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 8'hC1, 32'h0,  32'h1,  1'b0, 4'd1},   // R1 unlocked
    {1'b0, 8'hC5, 32'h0,  32'h1,  1'b0, 4'd2},   // R2
    {1'b1, 8'h00, 32'hA0, 32'h0,  1'b0, 4'd7},   // R7
    {1'b1, 8'h01, 32'hA1, 32'h0,  1'b0, 4'd7},
    {1'b1, 8'h02, 32'hA2, 32'h0,  1'b0, 4'd7},
    {1'b1, 8'h03, 32'hA3, 32'h0,  1'b0, 4'd7},
    {1'b0, 8'h02, 32'h0,  32'hA2, 1'b0, 4'd7},
    {1'b0, 8'hC2, 32'h0,  32'h0,  1'b1, 4'd8},   // R8
    {1'b1, 8'hC0, KEY,    32'h0,  1'b0, 4'd5},   // R5
    {1'b0, 8'hC1, 32'h0,  32'h3,  1'b0, 4'd1},
    {1'b0, 8'h00, 32'h0,  32'h0,  1'b1, 4'd6},   // R6
    {1'b1, 8'h01, 32'hFF, 32'h0,  1'b1, 4'd6},
    {1'b0, 8'hC2, 32'h0,  32'hA0, 1'b0, 4'd9},   // R9
    {1'b0, 8'hC2, 32'h0,  32'hA1, 1'b0, 4'd6},   // refused write left A1
    {1'b0, 8'hC2, 32'h0,  32'hA2, 1'b0, 4'd9},
    {1'b0, 8'hC2, 32'h0,  32'hA3, 1'b0, 4'd9},
    {1'b0, 8'hC2, 32'h0,  32'hA0, 1'b0, 4'd9},   // wrap
    {1'b1, 8'hC0, KEY,    32'h0,  1'b0, 4'd5},   // pointer back to 0
    {1'b1, 8'hC2, 32'hB0, 32'h0,  1'b0, 4'd9},
    {1'b1, 8'hC2, 32'hB1, 32'h0,  1'b0, 4'd9},
    {1'b1, 8'hC2, 32'hB2, 32'h0,  1'b0, 4'd9},
    {1'b1, 8'hC2, 32'hB3, 32'h0,  1'b0, 4'd9},
    {1'b1, 8'hC0, 32'h1,  32'h0,  1'b0, 4'd5},   // other value unlocks
    {1'b0, 8'hC1, 32'h0,  32'h1,  1'b0, 4'd5},
    {1'b0, 8'h00, 32'h0,  32'hB0, 1'b0, 4'd9},
    {1'b0, 8'h03, 32'h0,  32'hB3, 1'b0, 4'd9}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit sel, input bit lost, input bit w, input logic [7:0] a,
                     input logic [31:0] wd, input logic [31:0] erd, input bit eerr, input string tag);
    @(negedge clk);
    we = w; addr = a; wdata = wd;
    if (sel) begin req_s = 1'b1; lost_s = lost; end
    else begin req_f = 1'b1; lost_f = lost; end
    @(negedge clk);
    req_f = 1'b0; req_s = 1'b0; lost_f = 1'b0; lost_s = 1'b0;
    if (sel) begin
      check(s_vld && s_rd == erd && s_err == eerr, tag, {s_vld, s_err, s_rd[29:0]}, {2'b10 | 2'(eerr), erd[29:0]});
    end else begin
      check(f_vld && f_rd == erd && f_err == eerr, tag, {f_vld, f_err, f_rd[29:0]}, {2'b10 | 2'(eerr), erd[29:0]});
    end
  endtask

  task automatic lost_pulse(input bit sel);
    @(negedge clk);
    if (sel) lost_s = 1'b1; else lost_f = 1'b1;
    @(negedge clk);
    lost_f = 1'b0; lost_s = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!f_vld && !s_vld, "R12 reset idle", {30'b0, f_vld, s_vld}, 32'h0);
    acc(1'b0, 1'b0, 1'b0, 8'hC1, 0, 32'h1, 1'b0, "R1 reset lock status");
    @(negedge clk);
    check(!f_vld, "R12 single response", {31'b0, f_vld}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d vector %0d", v[3:0], i);
      acc(1'b0, 1'b0, v[77], v[76:69], v[68:37], v[36:5], v[4], t);
    end

    lost_pulse(1'b0);
    acc(1'b0, 1'b0, 1'b0, 8'h01, 0, 32'h0, 1'b1, "R6 sticky blocks");
    acc(1'b0, 1'b0, 1'b0, 8'hC5, 0, 32'h3, 1'b0, "R3 read sticky");
    acc(1'b0, 1'b0, 1'b0, 8'hC5, 0, 32'h1, 1'b0, "R3 sticky cleared");
    acc(1'b0, 1'b0, 1'b0, 8'h01, 0, 32'h0, 1'b0, "R4 regs zeroed");

    acc(1'b0, 1'b0, 1'b1, 8'hC0, KEY, 32'h0, 1'b0, "R5 lock");
    acc(1'b0, 1'b0, 1'b1, 8'hC2, 32'h77, 32'h0, 1'b0, "R9 sr write");
    lost_pulse(1'b0);
    acc(1'b0, 1'b0, 1'b1, 8'hC2, 32'h88, 32'h0, 1'b0, "R4 sr after loss");
    acc(1'b0, 1'b0, 1'b0, 8'hC2, 0, 32'h0, 1'b0, "R4 reg1 zeroed");
    acc(1'b0, 1'b0, 1'b1, 8'hC0, 32'h0, 32'h0, 1'b0, "R5 unlock");
    acc(1'b0, 1'b0, 1'b0, 8'hC5, 0, 32'h3, 1'b0, "R3 clear");
    acc(1'b0, 1'b0, 1'b0, 8'h00, 0, 32'h88, 1'b0, "R4 pointer reset");

    acc(1'b0, 1'b1, 1'b0, 8'hC5, 0, 32'h1, 1'b0, "R3 loss with read");
    acc(1'b0, 1'b0, 1'b0, 8'hC5, 0, 32'h3, 1'b0, "R3 loss wins");
    acc(1'b0, 1'b0, 1'b0, 8'h40, 0, 32'h0, 1'b0, "R10 unmapped");
    acc(1'b0, 1'b0, 1'b1, 8'hC1, 32'h5, 32'h0, 1'b0, "R10 status write");

    acc(1'b1, 1'b0, 1'b0, 8'hC1, 0, 32'h0, 1'b0, "R1 single status");
    acc(1'b1, 1'b0, 1'b1, 8'hC0, KEY, 32'h0, 1'b0, "R11 key ignored");
    acc(1'b1, 1'b0, 1'b0, 8'hC1, 0, 32'h0, 1'b0, "R11 still unlocked");
    acc(1'b1, 1'b0, 1'b1, 8'h02, 32'h5A, 32'h0, 1'b0, "R11 trace write");
    lost_pulse(1'b1);
    acc(1'b1, 1'b0, 1'b0, 8'hC5, 0, 32'h1, 1'b0, "R2 single pd");
    acc(1'b1, 1'b0, 1'b0, 8'h02, 0, 32'h5A, 1'b0, "R11 loss no effect");
    acc(1'b1, 1'b0, 1'b1, 8'hC2, 32'h11, 32'h0, 1'b0, "R11 sr write");
    acc(1'b1, 1'b0, 1'b0, 8'hC2, 0, 32'h0, 1'b0, "R11 sr read");
    acc(1'b1, 1'b0, 1'b0, 8'h00, 0, 32'h0, 1'b0, "R11 sr write ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule